// File: doc/BRIEF.md
# Timed Register Write Guard

This block decides whether writes to a group of protected configuration registers are accepted. It starts unprotected when power-on reset is released and protects itself after a fixed number of one-second ticks. While protected, software opens a short write window by writing two key values, one after the other, to a key port. The window closes after a smaller number of ticks, or at once when software asks for it to close. Writes attempted while protected are dropped and leave a sticky error flag, which software clears by writing 1.

The block is controlled by a four-state machine. `ST_POR_OPEN` is the state after reset, and writes pass. `ST_LOCKED` blocks writes. `ST_ARMED` also blocks writes and means the first key has been accepted. `ST_SW_OPEN` is the software window, and writes pass. The transitions are as follows:
- *power-on expiry*: `ST_POR_OPEN` to `ST_LOCKED`.
- *arm*: `ST_LOCKED` to `ST_ARMED` on the first key.
- *re-arm*: `ST_ARMED` to `ST_ARMED` on the first key again.
- *disarm*: `ST_ARMED` to `ST_LOCKED` on any other key value.
- *open*: `ST_ARMED` to `ST_SW_OPEN` on the second key.
- *window expiry*: `ST_SW_OPEN` to `ST_LOCKED`.
- *forced lock*: any state to `ST_LOCKED` on `lock_req`.

A tick counter runs only in the two open states. It starts from zero each time one of them is entered.

Top module: `wr_guard_top`

## Requirements
- R1: After reset `prot_active` is 0 and `bus_err` is 0. A `wr_req` in the cycles after reset gives `wr_grant` = 1.
- R2: In the power-on state, the cycle that samples the POR_SECS-th `tick_1hz` pulse (default 15) moves the block to locked. `prot_active` reads 1 from the next cycle. After 14 ticks it still reads 0.
- R3: A software window closes on the UNLOCK_SECS-th tick (default 2) counted after it opens, so it may be up to one tick short of the full time. After 1 tick `prot_active` is still 0.
- R4: While locked, a key write of KEY_ARM (default 16'hA5C3) followed by a key write of KEY_OPEN (default 16'h3C5A) opens the window. `prot_active` reads 0 from the cycle after the second key write. Cycles with no key write between the two are allowed.
- R5: After KEY_ARM, a key write of any value other than KEY_ARM or KEY_OPEN restarts the sequence, so a following KEY_OPEN alone does not unlock. A repeated KEY_ARM keeps the sequence armed. KEY_OPEN alone while locked does nothing.
- R6: Key writes during an open window are ignored and do not restart its tick count.
- R7: `lock_req` makes `prot_active` read 1 from the next cycle, from any state. It takes priority over key writes and ticks in the same cycle, and it cancels a power-on or software window.
- R8: `wr_grant` equals `wr_req` while `prot_active` is 0 and is 0 while `prot_active` is 1, in the same cycle.
- R9: A `wr_req` while protected sets `bus_err` from the next cycle. The flag holds until a cycle with `berr_clr` = 1 and no blocked write. A blocked write in the same cycle as `berr_clr` keeps the flag at 1.
- R10: Ticks while locked or armed have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_1hz | input | 1 | One-cycle enable pulse once per second |
| key_wr | input | 1 | Write strobe of the key port |
| key_data | input | KEY_W | Value written to the key port |
| lock_req | input | 1 | Software request to lock now |
| wr_req | input | 1 | Write attempt to a protected register |
| berr_clr | input | 1 | Write-1-to-clear of the bus error flag |
| wr_grant | output | 1 | Write to protected register is accepted |
| prot_active | output | 1 | Status: write protection in force |
| bus_err | output | 1 | Sticky flag: a write was blocked |

## Verification
A wrong state in this block shows up at `prot_active` and `wr_grant` in the very next cycle, because both come straight from the state register. A wrong tick count stays hidden until the tick that should close a window. It then shows as a lock that arrives one tick early or late, so the bench counts ticks exactly up to each boundary. A lost or stuck error flag is visible at `bus_err` one cycle after a blocked write or a clear.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

    typedef enum logic [1:0] {
        ST_POR_OPEN = 2'd0,
        ST_LOCKED   = 2'd1,
        ST_ARMED    = 2'd2,
        ST_SW_OPEN  = 2'd3
    } guard_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wr_guard_timer.sv
module wr_guard_timer
    import wr_guard_pkg::*;
#(
    parameter int unsigned POR_SECS    = 15,
    parameter int unsigned UNLOCK_SECS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic por_phase,
    input  logic tick_1hz,
    output logic expire
);
    localparam int unsigned LONGEST = max_u(POR_SECS, UNLOCK_SECS);
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] POR_LAST = CNT_W'(POR_SECS - 1);
    localparam logic [CNT_W-1:0] SW_LAST  = CNT_W'(UNLOCK_SECS - 1);

    logic [CNT_W-1:0] sec_cnt_q;
    logic [CNT_W-1:0] last_val;

    always_comb begin
        last_val = por_phase ? POR_LAST : SW_LAST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_cnt_q <= '0;
        end else if (!run) begin
            sec_cnt_q <= '0;
        end else if (tick_1hz) begin
            sec_cnt_q <= sec_cnt_q + 1'b1;
        end
    end

    always_comb begin
        expire = run && tick_1hz && (sec_cnt_q == last_val);
    end

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (sec_cnt_q <= last_val)); // R3

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (sec_cnt_q == '0)); // R10

endmodule

// File: rtl/wr_guard_fsm.sv
module wr_guard_fsm
    import wr_guard_pkg::*;
#(
    parameter int unsigned KEY_W    = 16,
    parameter logic [KEY_W-1:0] KEY_ARM  = 16'hA5C3,
    parameter logic [KEY_W-1:0] KEY_OPEN = 16'h3C5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    input  logic             lock_req,
    input  logic             expire,
    output logic             open_win,
    output logic             por_phase,
    output logic             prot_active
);
    guard_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POR_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (lock_req) begin
            state_d = ST_LOCKED;
        end else begin
            unique case (state_q)
                ST_POR_OPEN, ST_SW_OPEN: begin
                    if (expire) state_d = ST_LOCKED;
                end
                ST_LOCKED: begin
                    if (key_wr && key_data == KEY_ARM) state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (key_wr) begin
                        if (key_data == KEY_OPEN)     state_d = ST_SW_OPEN;
                        else if (key_data == KEY_ARM) state_d = ST_ARMED;
                        else                          state_d = ST_LOCKED;
                    end
                end
                default: state_d = ST_LOCKED;
            endcase
        end
    end

    always_comb begin
        open_win    = 1'b0;
        por_phase   = 1'b0;
        prot_active = 1'b1;
        unique case (state_q)
            ST_POR_OPEN: begin
                open_win    = 1'b1;
                por_phase   = 1'b1;
                prot_active = 1'b0;
            end
            ST_SW_OPEN: begin
                open_win    = 1'b1;
                prot_active = 1'b0;
            end
            ST_LOCKED, ST_ARMED: begin
                prot_active = 1'b1;
            end
            default: prot_active = 1'b1;
        endcase
    end

    AST_LOCK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> (state_q == ST_LOCKED)); // R7

    AST_KEY_PAIR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && key_wr && key_data == KEY_OPEN && !lock_req)
        |=> (state_q == ST_SW_OPEN)); // R4

    AST_NO_POR_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_POR_OPEN) |=> (state_q != ST_POR_OPEN)); // R2

    AST_LOCKED_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && !key_wr) |=> (state_q == ST_LOCKED)); // R10

    AST_OPEN_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SW_OPEN && !lock_req && !expire) |=> (state_q == ST_SW_OPEN)); // R6

endmodule

// File: rtl/wr_guard_errflag.sv
module wr_guard_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic blocked,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (blocked) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    AST_BERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> flag); // R9

    AST_BERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag); // R9

endmodule

// File: rtl/wr_guard_top.sv
module wr_guard_top
    import wr_guard_pkg::*;
#(
    parameter int unsigned POR_SECS    = 15,
    parameter int unsigned UNLOCK_SECS = 2,
    parameter int unsigned KEY_W       = 16,
    parameter logic [KEY_W-1:0] KEY_ARM  = 16'hA5C3,
    parameter logic [KEY_W-1:0] KEY_OPEN = 16'h3C5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1hz,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    input  logic             lock_req,
    input  logic             wr_req,
    input  logic             berr_clr,
    output logic             wr_grant,
    output logic             prot_active,
    output logic             bus_err
);
    logic open_win;
    logic por_phase;
    logic expire;
    logic blocked;

    wr_guard_fsm #(
        .KEY_W    (KEY_W),
        .KEY_ARM  (KEY_ARM),
        .KEY_OPEN (KEY_OPEN)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_data    (key_data),
        .lock_req    (lock_req),
        .expire      (expire),
        .open_win    (open_win),
        .por_phase   (por_phase),
        .prot_active (prot_active)
    );

    wr_guard_timer #(
        .POR_SECS    (POR_SECS),
        .UNLOCK_SECS (UNLOCK_SECS)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (open_win),
        .por_phase (por_phase),
        .tick_1hz  (tick_1hz),
        .expire    (expire)
    );

    always_comb begin
        wr_grant = wr_req && open_win;
        blocked  = wr_req && !open_win;
    end

    wr_guard_errflag err_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .blocked (blocked),
        .clr     (berr_clr),
        .flag    (bus_err)
    );

    AST_NO_GRANT_WHEN_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active |-> !wr_grant); // R8

endmodule

// File: tb/wr_guard_top_tb_top.sv
module wr_guard_top_tb_top;
    localparam logic [15:0] K_ARM  = 16'hA5C3;
    localparam logic [15:0] K_OPEN = 16'h3C5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1hz = 1'b0, key_wr = 1'b0, lock_req = 1'b0, wr_req = 1'b0, berr_clr = 1'b0;
    logic [15:0] key_data = 16'h0;
    logic wr_grant, prot_active, bus_err;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // behavioural reference: mode 0 power-on window, 1 locked, 2 armed, 3 sw window
    int  m_mode = 0;
    int  m_ticks = 0;
    bit  m_berr = 1'b0;

    always #2 clk = ~clk;

    wr_guard_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .key_wr(key_wr),
        .key_data(key_data), .lock_req(lock_req), .wr_req(wr_req),
        .berr_clr(berr_clr), .wr_grant(wr_grant), .prot_active(prot_active),
        .bus_err(bus_err)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_ticks = 0; m_berr = 1'b0;
        end else begin
            bit is_open;
            is_open = (m_mode == 0) || (m_mode == 3);
            if (wr_req && !is_open) m_berr = 1'b1;
            else if (berr_clr)      m_berr = 1'b0;
            if (lock_req) begin
                m_mode = 1; m_ticks = 0;
            end else if (is_open) begin
                if (tick_1hz) begin
                    m_ticks = m_ticks + 1;
                    if (m_ticks == ((m_mode == 0) ? 15 : 2)) begin
                        m_mode = 1; m_ticks = 0;
                    end
                end
            end else if (m_mode == 1) begin
                if (key_wr && key_data == K_ARM) m_mode = 2;
            end else if (key_wr) begin
                if (key_data == K_OPEN) begin m_mode = 3; m_ticks = 0; end
                else if (key_data != K_ARM) m_mode = 1;
            end
        end
    end

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // sample all outputs against the model, away from the rising edge
    task automatic cmp_model();
        bit exp_open;
        exp_open = (m_mode == 0) || (m_mode == 3);
        check_bit(cur_req, "prot_active", prot_active, !exp_open);
        check_bit(cur_req, "wr_grant", wr_grant, wr_req && exp_open);
        check_bit(cur_req, "bus_err", bus_err, m_berr);
    endtask

    task automatic cyc(input bit t, input bit kw, input logic [15:0] kd,
                       input bit lr, input bit wr, input bit bc);
        @(negedge clk);
        cmp_model();
        tick_1hz = t; key_wr = kw; key_data = kd; lock_req = lr; wr_req = wr; berr_clr = bc;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 0, 0, 0);
    endtask

    task automatic tick();
        cyc(1, 0, 16'h0, 0, 0, 0);
        idle(2);
    endtask

    task automatic key(input logic [15:0] v);
        cyc(0, 1, v, 0, 0, 0);
        idle(1);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick_1hz = 0; key_wr = 0; key_data = 0; lock_req = 0; wr_req = 0; berr_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        apply_reset();
        cur_req = "R1";
        idle(1);
        check_bit("R1", "prot_active after reset", prot_active, 1'b0);
        check_bit("R1", "bus_err after reset", bus_err, 1'b0);
        cyc(0, 0, 16'h0, 0, 1, 0);
        #1 check_bit("R1", "wr_grant in power-on window", wr_grant, 1'b1);
        idle(2);

        cur_req = "R2";
        for (int i = 0; i < 14; i++) tick();
        check_bit("R2", "still open after 14 ticks", prot_active, 1'b0);
        tick();
        check_bit("R2", "locked after 15th tick", prot_active, 1'b1);

        cur_req = "R10";
        for (int i = 0; i < 20; i++) tick();
        check_bit("R10", "ticks while locked", prot_active, 1'b1);

        cur_req = "R8";
        cyc(0, 0, 16'h0, 0, 1, 0);
        #1 check_bit("R8", "no grant while locked", wr_grant, 1'b0);
        cur_req = "R9";
        idle(1);
        check_bit("R9", "bus_err set by blocked write", bus_err, 1'b1);
        idle(3);
        check_bit("R9", "bus_err holds", bus_err, 1'b1);
        cyc(0, 0, 16'h0, 0, 0, 1);
        idle(1);
        check_bit("R9", "bus_err cleared", bus_err, 1'b0);
        cyc(0, 0, 16'h0, 0, 1, 1);
        idle(1);
        check_bit("R9", "set wins over clear", bus_err, 1'b1);
        cyc(0, 0, 16'h0, 0, 0, 1);
        idle(1);

        cur_req = "R4";
        key(K_ARM);
        check_bit("R4", "armed still protected", prot_active, 1'b1);
        key(K_OPEN);
        check_bit("R4", "open after key pair", prot_active, 1'b0);
        cyc(0, 0, 16'h0, 0, 1, 0);
        #1 check_bit("R8", "grant in sw window", wr_grant, 1'b1);
        cur_req = "R3";
        tick();
        check_bit("R3", "open after 1 tick", prot_active, 1'b0);
        tick();
        check_bit("R3", "locked after 2 ticks", prot_active, 1'b1);

        cur_req = "R5";
        key(K_OPEN);
        check_bit("R5", "second key alone", prot_active, 1'b1);
        key(K_ARM);
        key(16'h1234);
        key(K_OPEN);
        check_bit("R5", "wrong key restarts", prot_active, 1'b1);
        key(K_ARM);
        idle(3);
        tick();
        cur_req = "R10";
        key(K_ARM);
        cur_req = "R5";
        key(K_OPEN);
        check_bit("R5", "re-arm and gaps open", prot_active, 1'b0);

        cur_req = "R6";
        idle(2);
        tick();
        key(K_ARM);
        key(K_OPEN);
        key(16'hFFFF);
        check_bit("R6", "keys ignored while open", prot_active, 1'b0);
        tick();
        check_bit("R6", "window not restarted", prot_active, 1'b1);

        cur_req = "R7";
        key(K_ARM);
        key(K_OPEN);
        cyc(1, 0, 16'h0, 1, 0, 0);
        idle(1);
        check_bit("R7", "lock cancels sw window", prot_active, 1'b1);
        key(K_ARM);
        cyc(0, 1, K_OPEN, 1, 0, 0);
        idle(1);
        check_bit("R7", "lock beats open key", prot_active, 1'b1);
        key(K_OPEN);
        check_bit("R7", "sequence reset by lock", prot_active, 1'b1);
        apply_reset();
        idle(2);
        tick();
        cyc(0, 0, 16'h0, 1, 0, 0);
        idle(1);
        check_bit("R7", "lock cancels power-on window", prot_active, 1'b1);
        idle(3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule